// File: doc/BRIEF.md
# Scalar Float Compare-Predicate Unit

This unit compares two IEEE-754 binary32 values under one of 32 predicates. It returns a 32-bit mask in the low lane of a 128-bit result: all ones when the predicate holds and all zeros when it fails. The first operand is the low lane of a 128-bit source. The second operand is a separate 32-bit source. The predicates combine three choices:
- a relation: equal, less, less-or-equal, greater, greater-or-equal, unordered, always, or never;
- what an unordered pair yields;
- whether a quiet NaN raises the invalid flag.

In the same cycle the unit reports an invalid flag and a denormal flag, so that surrounding logic can trap or accumulate them.

The unit has two modes. In legacy mode only the three low bits of the 8-bit immediate choose the predicate. In extended mode the five low bits choose it. In both modes the first source is also the destination, so bits 127:32 of the result carry the first source's upper lanes.

The datapath accepts one operation every clock and never stalls. No ready signal exists in either direction. A strobe on `in_valid` produces a result with `out_valid` high on the next clock edge. The consumer must take the result in that cycle, because back-pressure cannot be applied. While no result is produced, the output registers hold their last value.

Top module: `fcmp_pred_unit`

## Requirements
- R1: The low lane of `result` is either 32'hFFFFFFFF (predicate true) or 32'h00000000 (predicate false). No other value appears there.
- R2: Zero operands compare equal regardless of sign. For example, 32'h80000000 equals 32'h00000000 under every equality and ordering relation.
- R3: A pair is unordered when either operand is a NaN. An unordered pair makes the plain relations (equal, less, less-or-equal, greater, greater-or-equal) false. The unordered predicate (code 3) is true only for such a pair, and the ordered predicate (code 7) is true only for a pair without a NaN.
- R4: The predicate code `c` is a 5-bit value. Codes 0 to 15 select these relations of first operand versus second operand:

  | Code | Relation |
  |---|---|
  | 0 | equal |
  | 1 | less |
  | 2 | less-or-equal |
  | 3 | unordered |
  | 4 | not-equal |
  | 5 | not-less |
  | 6 | not-less-or-equal |
  | 7 | ordered |
  | 8 | equal-or-unordered |
  | 9 | not-greater-or-equal |
  | 10 | not-greater |
  | 11 | never |
  | 12 | ordered-and-not-equal |
  | 13 | greater-or-equal |
  | 14 | greater |
  | 15 | always |

  The "not" forms (4, 5, 6, 9, 10) are true on an unordered pair. Codes 12, 13 and 14 are false on an unordered pair.
- R5: Code `c+16` gives the same mask as code `c`. It differs only in the quiet/signaling attribute named in R9.
- R6: When `ext_mode` is 0, the code is `imm[2:0]`, so only codes 0 to 7 are reachable and `imm[7:3]` has no effect. When `ext_mode` is 1, the code is `imm[4:0]` and `imm[7:5]` has no effect.
- R7: Bits 127:32 of `result` equal bits 127:32 of `src_a` from the accepted operation, in both modes.
- R8: `flag_invalid` is 1 whenever either operand is a signaling NaN.
- R9: `flag_invalid` is 1 when either operand is a quiet NaN and the predicate is a signaling one. The signaling codes are 1, 2, 5, 6, 9, 10, 13, 14, 16, 19, 20, 23, 24, 27, 28 and 31. With no NaN present, `flag_invalid` is 0.
- R10: `flag_denormal` is 1 exactly when either operand has a zero exponent field and a nonzero fraction.
- R11: Ordering follows the signed value:
  - a negative operand is below a positive one, unless both are zero;
  - between two negatives, the larger magnitude is the smaller value;
  - infinities order as ordinary extreme values.
- R12: A NaN has exponent 8'hFF and a nonzero fraction. It is quiet when fraction bit 22 (word bit 22) is 1 and signaling when that bit is 0. A quiet NaN under a quiet predicate leaves `flag_invalid` at 0.
- R13: `out_valid`, `result` and both flags update on the clock edge after `in_valid` is sampled high. `out_valid` is 0 after any cycle without `in_valid`, and the other outputs then hold their value. A synchronous `rst` clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe; every strobe is accepted |
| src_a | input | 128 | First source; low lane is the first operand |
| src_b | input | 32 | Second operand |
| imm | input | 8 | Predicate immediate |
| ext_mode | input | 1 | 0 = legacy three-bit predicate, 1 = extended five-bit predicate |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 128 | Mask lane plus carried upper lanes |
| flag_invalid | output | 1 | Invalid-operation flag |
| flag_denormal | output | 1 | Subnormal-operand flag |

## Verification
The unit has no state beyond its single output stage, so a wrong internal decision shows at the ports on the very next `out_valid`. Such a decision could be a misclassified NaN, a swapped sign rule, or a mis-decoded predicate bit. Each wrong decision corrupts the mask lane or one of the flags for the operand pair and code that reach it. The operand set therefore covers every class against every class and every code in both modes. That way a bad term in the decode, the classification or the sign-magnitude ordering is exposed within a few hundred cycles. A register that fails to hold, or fails to clear on reset, shows in the idle cycles between operations and right after reset.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;

  typedef struct packed {
    logic is_zero;
    logic is_sub;
    logic is_snan;
    logic is_qnan;
  } op_class_t;

  typedef enum logic [1:0] {
    REL_EQ   = 2'd0,
    REL_LT   = 2'd1,
    REL_LE   = 2'd2,
    REL_NONE = 2'd3
  } rel_e;

  typedef struct packed {
    rel_e rel;
    logic unord_val;
    logic invert;
    logic signaling;
  } pred_ctl_t;

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int FW = FRAC_W
) (
  input  logic [EW+FW:0] val,
  output op_class_t      cls
);
  localparam int QBIT = FW - 1;

  logic [EW-1:0] exp_f;
  logic [FW-1:0] frac_f;
  logic          exp_max;
  logic          exp_min;
  logic          frac_nz;

  assign exp_f   = val[EW+FW-1:FW];
  assign frac_f  = val[FW-1:0];
  assign exp_max = &exp_f;
  assign exp_min = ~|exp_f;
  assign frac_nz = |frac_f;

  always_comb begin
    cls.is_zero = exp_min & ~frac_nz;
    cls.is_sub  = exp_min & frac_nz;
    cls.is_qnan = exp_max & frac_nz & frac_f[QBIT];
    cls.is_snan = exp_max & frac_nz & ~frac_f[QBIT];
  end

endmodule

// File: rtl/fcmp_pred_decode.sv
module fcmp_pred_decode
  import fcmp_pkg::*;
#(
  parameter int CODE_W   = 5,
  parameter int LEGACY_W = 3
) (
  input  logic [CODE_W-1:0] code_raw,
  input  logic              ext_mode,
  output pred_ctl_t         ctl
);
  logic [CODE_W-1:0] code;
  logic [1:0]        kind;
  logic              quiet_swap;

  assign code = ext_mode ? code_raw
                         : {{(CODE_W-LEGACY_W){1'b0}}, code_raw[LEGACY_W-1:0]};
  assign kind       = code[1:0];
  assign quiet_swap = code[4];

  always_comb begin
    unique case (kind)
      2'd0:    ctl.rel = REL_EQ;
      2'd1:    ctl.rel = REL_LT;
      2'd2:    ctl.rel = REL_LE;
      default: ctl.rel = REL_NONE;
    endcase
    ctl.unord_val = code[3] ^ (kind == 2'd3);
    ctl.invert    = code[2];
    ctl.signaling = ((kind == 2'd1) | (kind == 2'd2)) ^ quiet_swap;
  end

endmodule

// File: rtl/fcmp_relation.sv
module fcmp_relation
  import fcmp_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  op_class_t    cls_a,
  input  op_class_t    cls_b,
  output logic         eq,
  output logic         lt,
  output logic         unord
);
  logic         sa;
  logic         sb;
  logic [W-2:0] mag_a;
  logic [W-2:0] mag_b;
  logic         both_zero;

  assign sa        = opa[W-1];
  assign sb        = opb[W-1];
  assign mag_a     = opa[W-2:0];
  assign mag_b     = opb[W-2:0];
  assign both_zero = cls_a.is_zero & cls_b.is_zero;
  assign unord     = cls_a.is_snan | cls_a.is_qnan | cls_b.is_snan | cls_b.is_qnan;

  always_comb begin
    eq = both_zero | (opa == opb);
    if (both_zero)     lt = 1'b0;
    else if (sa != sb) lt = sa;
    else if (!sa)      lt = mag_a < mag_b;
    else               lt = mag_a > mag_b;
  end

endmodule

// File: rtl/fcmp_pred_unit.sv
module fcmp_pred_unit
  import fcmp_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int IMM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] src_a,
  input  logic [WORD_W-1:0] src_b,
  input  logic [IMM_W-1:0] imm,
  input  logic             ext_mode,
  output logic             out_valid,
  output logic [VEC_W-1:0] result,
  output logic             flag_invalid,
  output logic             flag_denormal
);
  localparam int LANE_W = WORD_W;
  localparam int LANES  = VEC_W / LANE_W;
  localparam int CODE_W = 5;
  localparam int N_OPS  = 2;

  logic [WORD_W-1:0] ops [N_OPS];
  op_class_t         cls [N_OPS];
  pred_ctl_t         ctl;
  logic              eq, lt, unord;
  logic              hit;
  logic              any_snan, any_qnan, any_sub;
  logic [VEC_W-1:0]  nxt_result;
  logic              unused_imm_hi;

  assign ops[0] = src_a[LANE_W-1:0];
  assign ops[1] = src_b;
  assign unused_imm_hi = ^imm[IMM_W-1:CODE_W];

  for (genvar g = 0; g < N_OPS; g++) begin : g_cls
    fcmp_classify u_cls (
      .val (ops[g]),
      .cls (cls[g])
    );
  end

  fcmp_pred_decode #(.CODE_W(CODE_W)) u_dec (
    .code_raw (imm[CODE_W-1:0]),
    .ext_mode (ext_mode),
    .ctl      (ctl)
  );

  fcmp_relation u_rel (
    .opa   (ops[0]),
    .opb   (ops[1]),
    .cls_a (cls[0]),
    .cls_b (cls[1]),
    .eq    (eq),
    .lt    (lt),
    .unord (unord)
  );

  always_comb begin
    logic base;
    if (unord) begin
      base = ctl.unord_val;
    end else begin
      unique case (ctl.rel)
        REL_EQ:  base = eq;
        REL_LT:  base = lt;
        REL_LE:  base = lt | eq;
        default: base = 1'b0;
      endcase
    end
    hit = base ^ ctl.invert;
  end

  assign any_snan = cls[0].is_snan | cls[1].is_snan;
  assign any_qnan = cls[0].is_qnan | cls[1].is_qnan;
  assign any_sub  = cls[0].is_sub  | cls[1].is_sub;

  assign nxt_result[LANE_W-1:0] = {LANE_W{hit}};
  for (genvar l = 1; l < LANES; l++) begin : g_upper
    assign nxt_result[l*LANE_W +: LANE_W] = src_a[l*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      result        <= '0;
      flag_invalid  <= 1'b0;
      flag_denormal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result        <= nxt_result;
        flag_invalid  <= any_snan | (any_qnan & ctl.signaling);
        flag_denormal <= any_sub;
      end
    end
  end

endmodule

// File: rtl/fcmp_pred_chk.sv
module fcmp_pred_chk (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [127:0] src_a,
  input logic [31:0]  src_b,
  input logic [7:0]   imm,
  input logic         ext_mode,
  input logic         out_valid,
  input logic [127:0] result,
  input logic         flag_invalid,
  input logic         flag_denormal
);
  logic a_nan, b_nan, a_snan, b_snan, a_sub, b_sub, zero_pair, code0;

  assign a_nan     = (src_a[30:23] == 8'hFF) && (src_a[22:0] != 23'd0);
  assign b_nan     = (src_b[30:23] == 8'hFF) && (src_b[22:0] != 23'd0);
  assign a_snan    = a_nan && !src_a[22];
  assign b_snan    = b_nan && !src_b[22];
  assign a_sub     = (src_a[30:23] == 8'h00) && (src_a[22:0] != 23'd0);
  assign b_sub     = (src_b[30:23] == 8'h00) && (src_b[22:0] != 23'd0);
  assign zero_pair = (src_a[30:0] == 31'd0) && (src_b[30:0] == 31'd0);
  assign code0     = ext_mode ? (imm[4:0] == 5'd0) : (imm[2:0] == 3'd0);

  // R1
  mask_form_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (result[31:0] == 32'hFFFF_FFFF || result[31:0] == 32'h0));

  // R13
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R13
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result)));

  // R2
  signed_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && zero_pair && code0) |=> (result[31:0] == 32'hFFFF_FFFF));

  // R3
  unord_eq_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (a_nan || b_nan) && code0) |=> (result[31:0] == 32'h0));

  // R6
  legacy_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !ext_mode && imm[2:0] == 3'd3 && !a_nan && !b_nan)
      |=> (result[31:0] == 32'h0));

  // R7
  upper_copy_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (result[127:32] == $past(src_a[127:32])));

  // R8
  snan_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (a_snan || b_snan)) |=> flag_invalid);

  // R9
  no_nan_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !a_nan && !b_nan) |=> !flag_invalid);

  // R10
  denorm_flag_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (flag_denormal == $past(a_sub || b_sub)));

endmodule

bind fcmp_pred_unit fcmp_pred_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .src_a         (src_a),
  .src_b         (src_b),
  .imm           (imm),
  .ext_mode      (ext_mode),
  .out_valid     (out_valid),
  .result        (result),
  .flag_invalid  (flag_invalid),
  .flag_denormal (flag_denormal)
);

// File: tb/sim_fcmp_pred_unit.sv
`timescale 1ns/1ps
module sim_fcmp_pred_unit;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [127:0] src_a = '0;
  logic [31:0]  src_b = '0;
  logic [7:0]   imm = '0;
  logic         ext_mode = 1'b0;
  logic         out_valid;
  logic [127:0] result;
  logic         flag_invalid;
  logic         flag_denormal;

  int checks = 0;
  int fails  = 0;
  logic [31:0] vals [12];

  always #2 clk = ~clk;

  fcmp_pred_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
    .imm(imm), .ext_mode(ext_mode), .out_valid(out_valid), .result(result),
    .flag_invalid(flag_invalid), .flag_denormal(flag_denormal)
  );

  function automatic bit m_nan(logic [31:0] x);
    return x[30:23] == 8'hFF && x[22:0] != 0;
  endfunction

  function automatic longint m_key(logic [31:0] x);
    if (x[30:0] == 0) return 0;
    return x[31] ? -longint'(x[30:0]) : longint'(x[30:0]);
  endfunction

  function automatic bit m_truth(logic [31:0] a, logic [31:0] b, logic [4:0] c);
    bit un, e, l, g;
    un = m_nan(a) || m_nan(b);
    e = !un && m_key(a) == m_key(b);
    l = !un && m_key(a) <  m_key(b);
    g = !un && m_key(a) >  m_key(b);
    case (c[3:0])
      4'd0:  return e;
      4'd1:  return l;
      4'd2:  return l | e;
      4'd3:  return un;
      4'd4:  return !e;
      4'd5:  return !l;
      4'd6:  return !(l | e);
      4'd7:  return !un;
      4'd8:  return e | un;
      4'd9:  return l | un;
      4'd10: return l | e | un;
      4'd11: return 1'b0;
      4'd12: return l | g;
      4'd13: return g | e;
      4'd14: return g;
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit m_sig(logic [4:0] c);
    bit s;
    s = (c[3:0] inside {4'd1, 4'd2, 4'd5, 4'd6, 4'd9, 4'd10, 4'd13, 4'd14});
    return s ^ c[4];
  endfunction

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(logic [127:0] a, logic [31:0] b, logic [7:0] im, logic md);
    logic [4:0] c;
    bit an, bn, asn, bsn, qn, t, sub;
    string tl, ti;
    c   = md ? im[4:0] : {2'b00, im[2:0]};
    an  = m_nan(a[31:0]);
    bn  = m_nan(b);
    asn = an && !a[22];
    bsn = bn && !b[22];
    qn  = (an && a[22]) || (bn && b[22]);
    t   = m_truth(a[31:0], b, c);
    sub = (a[30:23] == 0 && a[22:0] != 0) || (b[30:23] == 0 && b[22:0] != 0);
    if (!md)                                   tl = "R6";
    else if (an || bn)                         tl = "R3";
    else if (a[30:0] == 0 && b[30:0] == 0)     tl = "R2";
    else if (c[4])                             tl = "R5";
    else if (a[31] != b[31] || a[30:23] == 8'hFF || b[30:23] == 8'hFF) tl = "R11";
    else                                       tl = "R4";
    if (asn || bsn)          ti = "R8";
    else if (qn && m_sig(c)) ti = "R9";
    else if (qn)             ti = "R12";
    else                     ti = "R9";
    src_a = a; src_b = b; imm = im; ext_mode = md; in_valid = 1'b1;
    @(negedge clk);
    chk("R13 out_valid", {127'd0, out_valid}, 128'd1);
    chk("R1 mask form", {127'd0, (result[31:0] == '1 || result[31:0] == '0)}, 128'd1);
    chk(tl, {96'd0, result[31:0]}, {96'd0, {32{t}}});
    chk("R7 upper", {32'd0, result[127:32]}, {32'd0, a[127:32]});
    chk(ti, {127'd0, flag_invalid}, {127'd0, (asn || bsn || (qn && m_sig(c)))});
    chk("R10", {127'd0, flag_denormal}, {127'd0, sub});
  endtask

  task automatic idle_cycle();
    logic [127:0] held;
    held = result;
    in_valid = 1'b0;
    src_a = {4{32'hDEAD_BEEF}};
    @(negedge clk);
    chk("R13 idle valid", {127'd0, out_valid}, 128'd0);
    chk("R13 idle hold", result, held);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    vals = '{32'h0000_0000, 32'h8000_0000, 32'h3F80_0000, 32'hBF80_0000,
             32'h4000_0000, 32'hC000_0000, 32'h7F80_0000, 32'hFF80_0000,
             32'h7FC0_0000, 32'h7FA0_0000, 32'h0000_0001, 32'h8000_0010};
    repeat (3) @(negedge clk);
    chk("R13 reset", {result, out_valid, flag_invalid, flag_denormal}, '0);
    rst = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 12; i++) begin
      for (int j = 0; j < 12; j++) begin
        for (int c = 0; c < 32; c++)
          run_op({$urandom, $urandom, $urandom, vals[i]}, vals[j],
                 {3'($urandom), 5'(c)}, 1'b1);
        for (int c = 0; c < 8; c++)
          run_op({$urandom, $urandom, $urandom, vals[i]}, vals[j],
                 {5'($urandom), 3'(c)}, 1'b0);
      end
      idle_cycle();
    end
    for (int k = 0; k < 600; k++) begin
      run_op({$urandom, $urandom, $urandom, $urandom}, $urandom,
             8'($urandom), 1'($urandom));
      if (k % 50 == 0) idle_cycle();
    end
    run_op({96'h1, 32'h3F80_0000}, 32'h3F80_0000, 8'h00, 1'b1);
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    chk("R13 sync reset", {result, out_valid, flag_invalid, flag_denormal}, '0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule